// File: doc/BRIEF.md
# Dual Store Queue Write Buffer

This unit gathers software stores into two independent 32-byte queues and writes each queue out as a whole 32-byte block on a word-wide memory write port. Stores are 32 or 64 bits wide and are accepted on every cycle. A store never waits, whatever either queue is doing. The queues cannot be read back through any port.

A flush command carries one address. Its bit 6 picks the queue, and the bits above bit 6 give the destination of the block. The queue keeps its contents after a flush, so software can flush one queue to several destinations and write the same data each time without storing it again. A flush that targets a queue with an earlier flush still pending or still sending is held with a stall. A flush to the other queue goes through at once. Flushes that wait for the memory port are served in the order they were accepted.

Top module: `sq_write_buffer`

## Requirements
- R1: After reset, mem_valid_o is low, fl_stall_o is low, and every word of both queues reads as zero when flushed.
- R2: A 32-bit store (st_wide_i low) writes st_data_i[31:0] into the word chosen by st_addr_i[4:2] of the queue chosen by st_addr_i[5], where 0 means queue 0. Every other word stays unchanged.
- R3: A 64-bit store (st_wide_i high) with st_addr_i[2] low writes st_data_i[31:0] to the even word and st_data_i[63:32] to the next word. With st_addr_i[2] high the store has no effect.
- R4: A flush selects the queue with fl_addr_i[6] and sends the block to fl_addr_i with bits 6:0 cleared.
- R5: A flush sends eight beats. Beat i carries word i at destination + 4*i, in ascending order. While mem_valid_o is high and mem_ready_i is low, valid, address and data hold steady.
- R6: When the memory port is idle, mem_valid_o rises in the cycle after a flush is accepted, with the destination address on mem_addr_o.
- R7: fl_stall_o is high exactly when fl_valid_i is high and the addressed queue has a flush pending or sending. It drops in the cycle after the last beat of that flush is accepted.
- R8: Stores into one queue are taken every cycle while the other queue has a flush pending or sending, and they appear in that queue's next flush.
- R9: A queue keeps its contents after a flush, so flushing it again sends identical data.
- R10: When both queues have flushes waiting, all beats of the earlier-accepted flush go out before any beat of the later one.
- R11: A flush to an idle queue is accepted without stall while the other queue is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store strobe |
| st_wide_i | input | 1 | 1: 64-bit store, 0: 32-bit store |
| st_addr_i | input | 32 | Store address (bit 5 queue, bits 4:2 word) |
| st_data_i | input | 64 | Store data, low word in bits 31:0 |
| fl_valid_i | input | 1 | Flush request, held by the issuer while stalled |
| fl_addr_i | input | 32 | Flush address (bit 6 queue, bits 31:7 destination) |
| fl_stall_o | output | 1 | Flush not taken this cycle |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Write beat accepted |
| mem_addr_o | output | 32 | Write beat byte address |
| mem_data_o | output | 32 | Write beat data |

## Verification
The flush path is tested with several store mixes. These cover single words at the first and last index, aligned double words, a misaligned double word that must leave its words untouched, and flush addresses with low-order garbage. Together they separate errors in word indexing, half ordering, queue selection and destination masking. Back-to-back flushes to both queues under a toggling ready separate issue-order errors from beat-hold errors. A flush held against a busy queue measures the exact stall length. A repeated flush of an unchanged queue shows whether contents survive a flush.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_ADDR_W   = 32;
  localparam int SQ_WORD_W   = 32;
  localparam int SQ_Q_BYTES  = 32;
  localparam int SQ_NUM_Q    = 2;
  localparam int SQ_FL_SEL   = 6;
endpackage

// File: rtl/sq_queue.sv
module sq_queue #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wide_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [2*WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [WORD_W-1:0]   rd_data_o
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic [IDX_W-1:0]  even_idx, odd_idx;
  logic              wide_ok;

  assign even_idx  = {wr_idx_i[IDX_W-1:1], 1'b0};
  assign odd_idx   = {wr_idx_i[IDX_W-1:1], 1'b1};
  assign wide_ok   = wide_i && !wr_idx_i[0];
  assign rd_data_o = mem_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      if (!wide_i) begin
        mem_q[wr_idx_i] <= wr_data_i[WORD_W-1:0];
      end else if (wide_ok) begin
        mem_q[even_idx] <= wr_data_i[WORD_W-1:0];
        mem_q[odd_idx]  <= wr_data_i[2*WORD_W-1:WORD_W];
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word_chk
    AST_WIDE_MISALIGN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wide_i && wr_idx_i[0] |=> $stable(mem_q[w])); // R3
    AST_NARROW_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !wide_i && (wr_idx_i != IDX_W'(w)) |=> $stable(mem_q[w])); // R2
  end
endmodule

// File: rtl/sq_flush_order.sv
module sq_flush_order #(
  parameter int DEPTH  = 2,
  parameter int BASE_W = 32,
  parameter int QSEL_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [QSEL_W-1:0] push_q_i,
  input  logic [BASE_W-1:0] push_base_i,
  input  logic              pop_i,
  output logic              head_valid_o,
  output logic [QSEL_W-1:0] head_q_o,
  output logic [BASE_W-1:0] head_base_o,
  output logic [DEPTH-1:0]  busy_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [QSEL_W-1:0] slot_q    [DEPTH];
  logic [BASE_W-1:0] slot_base [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  wr_idx;

  assign wr_idx       = cnt_q - CNT_W'(pop_i);
  assign head_valid_o = (cnt_q != '0);
  assign head_q_o     = slot_q[0];
  assign head_base_o  = slot_base[0];

  always_comb begin
    busy_o = '0;
    for (int q = 0; q < DEPTH; q++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((CNT_W'(i) < cnt_q) && (slot_q[i] == QSEL_W'(q))) busy_o[q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_q[i]    <= '0;
        slot_base[i] <= '0;
      end
    end else begin
      if (pop_i) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          slot_q[i]    <= slot_q[i+1];
          slot_base[i] <= slot_base[i+1];
        end
      end
      if (push_i) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (wr_idx == CNT_W'(i)) begin
            slot_q[i]    <= push_q_i;
            slot_base[i] <= push_base_i;
          end
        end
      end
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  AST_ORDER_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> (cnt_q < CNT_W'(DEPTH))); // R7
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o); // R10
  AST_ONE_PER_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !busy_o[push_q_i]); // R7
endmodule

// File: rtl/sq_beat_seq.sv
module sq_beat_seq #(
  parameter int IDX_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int BYTE_OFF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_valid_i,
  input  logic [ADDR_W-1:0] head_base_i,
  input  logic              mem_ready_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  beat_o,
  output logic              done_o
);
  logic [IDX_W-1:0] beat_q;
  logic             fire;

  assign fire        = head_valid_i && mem_ready_i;
  assign done_o      = fire && (&beat_q);
  assign mem_valid_o = head_valid_i;
  assign beat_o      = beat_q;
  assign mem_addr_o  = head_base_i |
                       {{(ADDR_W-IDX_W-BYTE_OFF){1'b0}}, beat_q, {BYTE_OFF{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   beat_q <= '0;
    else if (fire) beat_q <= beat_q + 1'b1;
  end

  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)); // R5
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !done_o |=> mem_valid_o &&
      (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1 << BYTE_OFF))); // R5
endmodule

// File: rtl/sq_write_buffer.sv
module sq_write_buffer
  import sq_pkg::*;
#(
  parameter int ADDR_W  = SQ_ADDR_W,
  parameter int WORD_W  = SQ_WORD_W,
  parameter int Q_BYTES = SQ_Q_BYTES,
  parameter int FL_SEL  = SQ_FL_SEL
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                st_valid_i,
  input  logic                st_wide_i,
  input  logic [ADDR_W-1:0]   st_addr_i,
  input  logic [2*WORD_W-1:0] st_data_i,
  input  logic                fl_valid_i,
  input  logic [ADDR_W-1:0]   fl_addr_i,
  output logic                fl_stall_o,
  output logic                mem_valid_o,
  input  logic                mem_ready_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_data_o
);
  localparam int NUM_Q    = SQ_NUM_Q;
  localparam int QSEL_W   = 1;
  localparam int WORDS    = Q_BYTES / (WORD_W / 8);
  localparam int IDX_W    = $clog2(WORDS);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int ST_SEL   = $clog2(Q_BYTES);

  logic [QSEL_W-1:0] st_q, fl_q, head_q;
  logic [IDX_W-1:0]  st_idx, beat;
  logic [ADDR_W-1:0] fl_base, head_base;
  logic [NUM_Q-1:0]  busy;
  logic              push, pop, head_valid;
  logic [WORD_W-1:0] rd_data [NUM_Q];
  logic              unused_addr_bits;

  assign st_q    = st_addr_i[ST_SEL];
  assign st_idx  = st_addr_i[ST_SEL-1:BYTE_OFF];
  assign fl_q    = fl_addr_i[FL_SEL];
  assign fl_base = {fl_addr_i[ADDR_W-1:FL_SEL+1], {(FL_SEL+1){1'b0}}};
  assign unused_addr_bits = ^{st_addr_i[ADDR_W-1:ST_SEL+1], st_addr_i[BYTE_OFF-1:0],
                              fl_addr_i[FL_SEL-1:0]};

  // stall only against the addressed queue; the other queue stays free
  assign fl_stall_o = fl_valid_i && busy[fl_q];
  assign push       = fl_valid_i && !busy[fl_q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    sq_queue #(
      .WORDS (WORDS),
      .WORD_W(WORD_W),
      .IDX_W (IDX_W)
    ) u_queue (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (st_valid_i && (st_q == QSEL_W'(g))),
      .wide_i   (st_wide_i),
      .wr_idx_i (st_idx),
      .wr_data_i(st_data_i),
      .rd_idx_i (beat),
      .rd_data_o(rd_data[g])
    );
  end

  sq_flush_order #(
    .DEPTH (NUM_Q),
    .BASE_W(ADDR_W),
    .QSEL_W(QSEL_W)
  ) u_order (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_q_i    (fl_q),
    .push_base_i (fl_base),
    .pop_i       (pop),
    .head_valid_o(head_valid),
    .head_q_o    (head_q),
    .head_base_o (head_base),
    .busy_o      (busy)
  );

  sq_beat_seq #(
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W),
    .BYTE_OFF(BYTE_OFF)
  ) u_beat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_valid_i(head_valid),
    .head_base_i (head_base),
    .mem_ready_i (mem_ready_i),
    .mem_valid_o (mem_valid_o),
    .mem_addr_o  (mem_addr_o),
    .beat_o      (beat),
    .done_o      (pop)
  );

  assign mem_data_o = rd_data[head_q];

  AST_STALL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_stall_o |-> fl_valid_i); // R7
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_valid_o && fl_valid_i && !fl_stall_o |=> mem_valid_o &&
      (mem_addr_o[ADDR_W-1:FL_SEL+1] == $past(fl_addr_i[ADDR_W-1:FL_SEL+1]))); // R6
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i && !st_valid_i |=> $stable(mem_data_o)); // R5
endmodule

// File: tb/tb_sq_write_buffer.sv
`timescale 1ns/1ps
module tb_sq_write_buffer;
  localparam real CLK_P = 5.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0;
  logic        st_wide_i = 1'b0;
  logic [31:0] st_addr_i = '0;
  logic [63:0] st_data_i = '0;
  logic        fl_valid_i = 1'b0;
  logic [31:0] fl_addr_i = '0;
  logic        fl_stall_o;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b1;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_data_o;

  sq_write_buffer dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]  op;    // 0 store32, 1 store64, 2 flush
    logic [31:0] addr;
    logic [63:0] data;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 32'h0000_0000, 64'h0000_0000_AAAA_0000},
    '{2'd0, 32'h0000_001C, 64'h0000_0000_0700_00A7},
    '{2'd1, 32'h0000_0008, 64'h3333_3333_2222_2222},
    '{2'd1, 32'h0000_0014, 64'hFFFF_FFFF_EEEE_EEEE},
    '{2'd0, 32'h0000_0024, 64'h0000_0000_1111_0001},
    '{2'd1, 32'h0000_0038, 64'h7777_7777_6666_6666},
    '{2'd2, 32'h8000_0000, 64'h0},
    '{2'd2, 32'h9000_00C4, 64'h0},
    '{2'd0, 32'h0000_0010, 64'h0000_0000_4444_4444},
    '{2'd0, 32'h0000_0004, 64'h0000_0000_0101_0101},
    '{2'd2, 32'h0000_1234, 64'h0},
    '{2'd2, 32'hA000_0040, 64'h0}
  };

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [2][8];
  logic [31:0] cap_addr [128];
  logic [31:0] cap_data [128];
  int cap_n = 0;

  always @(negedge clk_i) begin
    if (rst_ni && mem_valid_o && mem_ready_i && cap_n < 128) begin
      cap_addr[cap_n] = mem_addr_o;
      cap_data[cap_n] = mem_data_o;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // caller sits just after a rising edge
  task automatic store(input logic wide, input logic [31:0] a, input logic [63:0] d);
    int q = int'(a[5]);
    int w = int'(a[4:2]);
    st_valid_i = 1'b1; st_wide_i = wide; st_addr_i = a; st_data_i = d;
    @(posedge clk_i); #1;
    st_valid_i = 1'b0;
    if (!wide) mdl[q][w] = d[31:0];
    else if (!a[2]) begin
      mdl[q][w & 6] = d[31:0];
      mdl[q][w | 1] = d[63:32];
    end
  endtask

  task automatic issue_flush(input logic [31:0] a);
    fl_valid_i = 1'b1; fl_addr_i = a;
    forever begin
      @(negedge clk_i);
      if (!fl_stall_o) break;
    end
    @(posedge clk_i); #1;
    fl_valid_i = 1'b0;
  endtask

  task automatic wait_beats(input int upto);
    while (cap_n < upto) begin
      @(posedge clk_i); #1;
    end
  endtask

  task automatic check_block(input int first, input int q, input logic [31:0] dest, input string tag);
    for (int w = 0; w < 8; w++) begin
      chk(cap_addr[first+w] == dest + 32'(4*w), {tag, " addr"}, 64'(cap_addr[first+w]), 64'(dest + 32'(4*w)));
      chk(cap_data[first+w] == mdl[q][w], {tag, " data"}, 64'(cap_data[first+w]), 64'(mdl[q][w]));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    int n_st;
    for (int q = 0; q < 2; q++) for (int w = 0; w < 8; w++) mdl[q][w] = '0;
    #(CLK_P * 3);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1: reset state
    @(negedge clk_i);
    chk(mem_valid_o == 1'b0, "R1 valid", 64'(mem_valid_o), 64'd0);
    chk(fl_stall_o == 1'b0, "R1 stall", 64'(fl_stall_o), 64'd0);
    @(posedge clk_i); #1;

    // R6 and R1: flush of untouched queue 0
    base = cap_n;
    issue_flush(32'h4000_0000);
    @(negedge clk_i);
    chk(mem_valid_o == 1'b1, "R6 valid", 64'(mem_valid_o), 64'd1);
    chk(mem_addr_o == 32'h4000_0000, "R6 addr", 64'(mem_addr_o), 64'h4000_0000);
    wait_beats(base + 8);
    check_block(base, 0, 32'h4000_0000, "R1");

    // table walk: R2 R3 R4 R5 R9
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].op == 2'd2) begin
        base = cap_n;
        issue_flush(VECS[v].addr);
        wait_beats(base + 8);
        check_block(base, int'(VECS[v].addr[6]), VECS[v].addr & 32'hFFFF_FF80, "R2 R3 R4 R5");
      end else begin
        store(VECS[v].op == 2'd1, VECS[v].addr, VECS[v].data);
      end
    end

    // R8 R10 R11: both queues pending under backpressure
    mem_ready_i = 1'b0;
    base = cap_n;
    issue_flush(32'h5000_0000);
    store(1'b0, 32'h0000_0020, 64'h0000_0000_BEEF_0000);
    fl_valid_i = 1'b1; fl_addr_i = 32'h5100_0000;
    @(negedge clk_i);
    chk(fl_stall_o == 1'b1, "R7 busy", 64'(fl_stall_o), 64'd1);
    chk(cap_n == base && mem_valid_o, "R5 held", 64'(cap_n - base), 64'd0);
    @(posedge clk_i); #1;
    fl_addr_i = 32'h5200_0040;
    @(negedge clk_i);
    chk(fl_stall_o == 1'b0, "R11 idle queue", 64'(fl_stall_o), 64'd0);
    @(posedge clk_i); #1;
    fl_valid_i = 1'b0;
    while (cap_n < base + 16) begin
      mem_ready_i = ~mem_ready_i;
      @(posedge clk_i); #1;
    end
    mem_ready_i = 1'b1;
    check_block(base, 0, 32'h5000_0000, "R10 R5");
    check_block(base + 8, 1, 32'h5200_0000, "R10 R8");

    // R7 stall length, R9 repeat flush
    base = cap_n;
    fl_valid_i = 1'b1; fl_addr_i = 32'h6000_0040;
    @(negedge clk_i);
    @(posedge clk_i); #1;
    fl_addr_i = 32'h6100_0040;
    n_st = 0;
    forever begin
      @(negedge clk_i);
      if (fl_stall_o) n_st++;
      else break;
    end
    @(posedge clk_i); #1;
    fl_valid_i = 1'b0;
    chk(n_st == 8, "R7 stall cycles", 64'(n_st), 64'd8);
    wait_beats(base + 16);
    check_block(base, 1, 32'h6000_0000, "R9 first");
    check_block(base + 8, 1, 32'h6100_0000, "R9 repeat");

    repeat (3) @(posedge clk_i);
    #1;
    chk(cap_n == base + 16, "R7 no extra beats", 64'(cap_n - base), 64'd16);
    summary();
    $finish;
  end
endmodule